// File: doc/BRIEF.md
# Audio Receive Sample Queue with Service and Overrun Status

This block buffers received audio samples between a deserializer and a host. Each channel holds up to twelve 16-bit samples in first-in, first-out order. The deserializer offers one sample per frame on a push strobe. The host takes samples through a pop strobe, and the popped sample appears on a registered read-data output.

Each channel derives four status outputs from its fill level and its events:
- a service request that is high while six or more samples are waiting;
- a not-empty flag;
- a sticky overrun bit, set whenever an incoming sample has to be thrown away because the queue is full;
- an interrupt, raised by the overrun bit or by the service request when the host has enabled it.

The left and right channels are two copies of the same logic and have no effect on each other.

Each channel's level is tracked by a state machine with four states:
- `LV_EMPTY`: no samples held.
- `LV_LOW`: 1 to 5 samples held.
- `LV_HIGH`: 6 to 11 samples held.
- `LV_FULL`: 12 samples held.

The transitions are:
- fill: a push is accepted without a pop, so the state moves up a level when the count crosses 1, 6 or 12.
- drain: a pop is accepted without a push, so the state moves down a level when the count drops to 11, 5 or 0.
- hold: the count does not change, so the state stays where it is. This covers idle cycles, a push and a pop accepted together, a dropped push, and a pop on an empty queue.

Top module: `audio_rx_fifo`

## Requirements
- R1: After reset every channel is empty. Service request, overrun, not-empty and interrupt are 0, and read data is 0.
- R2: `not_empty_o[c]` is 1 exactly while channel c holds at least one sample. It never drives the interrupt by itself.
- R3: `svc_req_o[c]` is 1 while channel c holds 6 or more samples and 0 while it holds 5 or fewer. Popping clears it with no host action.
- R4: Samples leave in the order they arrived. An accepted pop puts the oldest sample on `pop_data_o[16c+15:16c]` in the cycle after the pop.
- R5: A push without a pop into a full channel (12 samples) is discarded. The stored samples and their order are unchanged.
- R6: Every discarded push sets `overrun_o[c]` in the next cycle, including when it had just been cleared.
- R7: `overrun_o[c]` stays at 1 until `ovr_clr_i[c]` is pulsed. If a clear and a discarded push happen in the same cycle, the bit stays 1.
- R8: `irq_o[c]` = `overrun_o[c]` OR (`svc_req_o[c]` AND `irq_mask_i[c]`). A mask value of 1 enables the service request and 0 suppresses it.
- R9: A pop on an empty channel leaves the read data, the level and all status unchanged.
- R10: A push and a pop in the same cycle on a full channel both take effect. The channel stays full and no overrun is raised.
- R11: Activity on one channel has no effect on the other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 2 | Per-channel push strobe (bit 0 left, bit 1 right) |
| push_data_i | input | 32 | Per-channel incoming sample, 16 bits per channel |
| pop_i | input | 2 | Per-channel pop strobe |
| ovr_clr_i | input | 2 | Per-channel overrun clear, write-one-to-clear |
| irq_mask_i | input | 2 | Per-channel service-request interrupt enable |
| pop_data_o | output | 32 | Per-channel last popped sample |
| svc_req_o | output | 2 | Service request, level at or above half |
| overrun_o | output | 2 | Sticky overrun status |
| not_empty_o | output | 2 | Not-empty flag |
| irq_o | output | 2 | Interrupt request |

## Verification
The hardest condition to reach is a full channel that receives pushes while its overrun bit is being cleared. This covers a clear on its own, a clear in the same cycle as a discarded push, and a push together with a pop that must not count as an overrun. The bench reaches it by filling one channel to exactly twelve through a level-by-level sweep. It then keeps that channel full while it steps through each combination of push, pop and clear in turn, and it checks the other channel every cycle to confirm that it is unaffected.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
    typedef enum logic [1:0] {
        LV_EMPTY = 2'd0,
        LV_LOW   = 2'd1,
        LV_HIGH  = 2'd2,
        LV_FULL  = 2'd3
    } level_e;
endpackage

// File: rtl/rx_level_ctrl.sv
module rx_level_ctrl
    import audio_rx_pkg::*;
#(
    parameter int DEPTH     = 12,
    parameter int SVC_LEVEL = DEPTH / 2,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic wr_en,
    output logic rd_en,
    output logic ovr_set,
    output logic svc_o,
    output logic not_empty_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    level_e state_q, state_d;
    logic is_full, is_empty;

    // acceptance decisions
    always_comb begin
        rd_en   = pop && !is_empty;
        wr_en   = push && (!is_full || rd_en);
        ovr_set = push && is_full && !rd_en;
        cnt_d   = cnt_q;
        if (wr_en && !rd_en) cnt_d = cnt_q + 1'b1;
        else if (rd_en && !wr_en) cnt_d = cnt_q - 1'b1;
    end

    // transitions: fill / drain / hold, selected by the next count
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_EMPTY: if (cnt_d != '0) state_d = LV_LOW;
            LV_LOW: begin
                if (cnt_d == '0) state_d = LV_EMPTY;
                else if (cnt_d >= CNT_W'(SVC_LEVEL)) state_d = LV_HIGH;
            end
            LV_HIGH: begin
                if (cnt_d < CNT_W'(SVC_LEVEL)) state_d = LV_LOW;
                else if (cnt_d == CNT_W'(DEPTH)) state_d = LV_FULL;
            end
            LV_FULL: if (cnt_d != CNT_W'(DEPTH)) state_d = LV_HIGH;
            default: state_d = LV_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LV_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        is_full     = 1'b0;
        is_empty    = 1'b0;
        svc_o       = 1'b0;
        not_empty_o = 1'b1;
        unique case (state_q)
            LV_EMPTY: begin is_empty = 1'b1; not_empty_o = 1'b0; end
            LV_LOW:   ;
            LV_HIGH:  svc_o = 1'b1;
            LV_FULL:  begin svc_o = 1'b1; is_full = 1'b1; end
            default:  ;
        endcase
    end

    p_svc_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(SVC_LEVEL - 1) && wr_en && !rd_en) |=> svc_o);
    p_svc_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(SVC_LEVEL) && rd_en && !wr_en) |=> !svc_o);
    p_drop_keeps_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> $stable(cnt_q));
    p_pass_through_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push && pop) |=> (cnt_q == CNT_W'(DEPTH)));
    p_ne_after_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> not_empty_o);
endmodule

// File: rtl/rx_sample_store.sv
module rx_sample_store #(
    parameter int DEPTH    = 12,
    parameter int SAMPLE_W = 16,
    localparam int PTR_W   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                rd_en,
    output logic [SAMPLE_W-1:0] rd_data
);
    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]    wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) begin
                rd_ptr  <= bump(rd_ptr);
                rd_data <= mem[rd_ptr];
            end
        end
    end

    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr < PTR_W'(DEPTH)) && (rd_ptr < PTR_W'(DEPTH)));
endmodule

// File: rtl/rx_overrun_status.sv
module rx_overrun_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic svc_i,
    input  logic mask_i,
    output logic ovr_o,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_o <= 1'b0;
        else        ovr_o <= set_i || (ovr_o && !clr_i);
    end

    assign irq_o = ovr_o || (svc_i && mask_i);

    p_set_each_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> ovr_o);
    p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> ovr_o);
    p_clear_works_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !ovr_o);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !clr_i) |=> ovr_o);
endmodule

// File: rtl/audio_rx_fifo.sv
module audio_rx_fifo #(
    parameter int NUM_CH   = 2,
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          push_i,
    input  logic [NUM_CH*SAMPLE_W-1:0] push_data_i,
    input  logic [NUM_CH-1:0]          pop_i,
    input  logic [NUM_CH-1:0]          ovr_clr_i,
    input  logic [NUM_CH-1:0]          irq_mask_i,
    output logic [NUM_CH*SAMPLE_W-1:0] pop_data_o,
    output logic [NUM_CH-1:0]          svc_req_o,
    output logic [NUM_CH-1:0]          overrun_o,
    output logic [NUM_CH-1:0]          not_empty_o,
    output logic [NUM_CH-1:0]          irq_o
);
    localparam int SVC_LEVEL = DEPTH / 2;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic wr_en, rd_en, ovr_set;

        rx_level_ctrl #(.DEPTH(DEPTH), .SVC_LEVEL(SVC_LEVEL)) ctrl_i (
            .clk(clk), .rst_n(rst_n),
            .push(push_i[c]), .pop(pop_i[c]),
            .wr_en(wr_en), .rd_en(rd_en), .ovr_set(ovr_set),
            .svc_o(svc_req_o[c]), .not_empty_o(not_empty_o[c])
        );

        rx_sample_store #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) store_i (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en), .wr_data(push_data_i[c*SAMPLE_W +: SAMPLE_W]),
            .rd_en(rd_en), .rd_data(pop_data_o[c*SAMPLE_W +: SAMPLE_W])
        );

        rx_overrun_status stat_i (
            .clk(clk), .rst_n(rst_n),
            .set_i(ovr_set), .clr_i(ovr_clr_i[c]),
            .svc_i(svc_req_o[c]), .mask_i(irq_mask_i[c]),
            .ovr_o(overrun_o[c]), .irq_o(irq_o[c])
        );

        p_empty_no_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !not_empty_o[c] |-> !svc_req_o[c]);
    end
endmodule

// File: tb/audio_rx_fifo_tb_top.sv
module audio_rx_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int W = 16;
    localparam int DEPTH = 12;

    logic clk = 0;
    logic rst_n = 0;
    logic [NCH-1:0] push = '0, pop = '0, clr = '0, mask = '0;
    logic [NCH*W-1:0] pdata = '0;
    logic [NCH*W-1:0] rdata;
    logic [NCH-1:0] svc, ovr, ne, irq;

    int checks = 0, errors = 0;

    logic [W-1:0] mq0[$];
    logic [W-1:0] mq1[$];
    logic [W-1:0] m_last [NCH];
    logic m_ovr [NCH];
    logic [W-1:0] tag = 16'h1000;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_rx_fifo #(.NUM_CH(NCH), .SAMPLE_W(W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(pdata),
        .pop_i(pop), .ovr_clr_i(clr), .irq_mask_i(mask),
        .pop_data_o(rdata), .svc_req_o(svc), .overrun_o(ovr),
        .not_empty_o(ne), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int qsize(input int c);
        return (c == 0) ? mq0.size() : mq1.size();
    endfunction

    task automatic check_all();
        for (int c = 0; c < NCH; c++) begin
            int n = qsize(c);
            logic esvc = (n >= 6);
            chk(ne[c] == (n > 0), "R2 not_empty", ne[c], n > 0);
            chk(svc[c] == esvc, "R3 svc_req", svc[c], esvc);
            chk(ovr[c] == m_ovr[c], "R6/R7 overrun", ovr[c], m_ovr[c]);
            chk(irq[c] == (m_ovr[c] | (esvc & mask[c])), "R8 irq", irq[c],
                m_ovr[c] | (esvc & mask[c]));
            chk(rdata[c*W +: W] == m_last[c], "R4 pop data", rdata[c*W +: W], m_last[c]);
        end
    endtask

    // one clock: drive at negedge, update model, sample at next negedge
    task automatic step(input logic [1:0] pu, input logic [1:0] po, input logic [1:0] cl);
        push = pu; pop = po; clr = cl;
        for (int c = 0; c < NCH; c++) pdata[c*W +: W] = tag + 16'(c * 16'h0100);
        for (int c = 0; c < NCH; c++) begin
            int n = qsize(c);
            bit pa = po[c] && n > 0;
            bit wa = pu[c] && (n < DEPTH || pa);
            bit st = pu[c] && n == DEPTH && !pa;
            if (pa) m_last[c] = (c == 0) ? mq0.pop_front() : mq1.pop_front();
            if (wa) begin
                if (c == 0) mq0.push_back(pdata[W-1:0]);
                else        mq1.push_back(pdata[2*W-1:W]);
            end
            m_ovr[c] = st | (m_ovr[c] & !cl[c]);
        end
        @(negedge clk);
        tag = tag + 1'b1;
        push = '0; pop = '0; clr = '0;
        check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin m_last[c] = '0; m_ovr[c] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(ne == 0 && svc == 0 && ovr == 0 && irq == 0 && rdata == 0, "R1 reset",
            {ne, svc, ovr, irq}, 0);
        check_all();

        // R9: pop on empty
        step(2'b00, 2'b11, 2'b00);
        // R3/R2/R11: sweep left channel through every level with mask on and off
        for (int m = 0; m < 2; m++) begin
            mask = m[0] ? 2'b01 : 2'b00;
            for (int i = 0; i < DEPTH; i++) step(2'b01, 2'b00, 2'b00);
            for (int i = 0; i < DEPTH; i++) step(2'b00, 2'b01, 2'b00);
        end
        // R9 again after data: pop_data must hold the last value
        step(2'b00, 2'b01, 2'b00);
        chk(rdata[W-1:0] == m_last[0], "R9 hold data", rdata[W-1:0], m_last[0]);

        // fill left, overrun cases R5, R6, R7
        mask = 2'b11;
        for (int i = 0; i < DEPTH; i++) step(2'b01, 2'b00, 2'b00);
        step(2'b01, 2'b00, 2'b00);           // R5/R6 drop
        chk(ovr[0] == 1, "R6 overrun set", ovr[0], 1);
        chk(ovr[1] == 0, "R11 other channel", ovr[1], 0);
        step(2'b00, 2'b00, 2'b01);           // R7 clear
        chk(ovr[0] == 0, "R7 clear", ovr[0], 0);
        step(2'b01, 2'b00, 2'b00);           // R6 re-set
        step(2'b01, 2'b00, 2'b01);           // R7 set beats clear
        chk(ovr[0] == 1, "R7 set wins", ovr[0], 1);
        step(2'b00, 2'b00, 2'b01);
        // R10: pass-through on full
        for (int i = 0; i < 4; i++) step(2'b01, 2'b01, 2'b00);
        chk(ovr[0] == 0, "R10 no overrun", ovr[0], 0);
        // R4/R5: drain and check order
        for (int i = 0; i < DEPTH + 2; i++) step(2'b00, 2'b01, 2'b00);

        // near-exhaustive combos on both channels
        for (int k = 0; k < 256; k++) begin
            logic [1:0] a = k[1:0], b = k[3:2], d = (k[7:4] == 0) ? 2'b11 : 2'b00;
            mask = k[5:4];
            step(a | 2'b11 & {2{k[6]}}, b, d);
        end
        for (int i = 0; i < 40; i++) step(2'b11, 2'b00, 2'b00);
        for (int k = 0; k < 64; k++) step(k[1:0], k[3:2], k[5:4]);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule